// File: doc/BRIEF.md
# Fixed-Latency Token Channel

This block is a one-way, point-to-point link between two units that step through simulated target cycles at their own host pace. In target terms the link looks like a delay line of `LATENCY` target cycles. On the host it is an elastic first-in first-out store of `DEPTH` entries (`DEPTH >= LATENCY`). The store is seeded with `LATENCY` copies of a reset token, so the receiving unit sees that default token on its first `LATENCY` target cycles. Each producer token then arrives exactly `LATENCY` receiver cycles after it was sent.

The producer pushes one token when it finishes a target cycle. It raises `send_req` with the token on `send_data`, and the push takes effect when `send_ok` is also high. The consumer pops one token when it starts a target cycle. It reads `recv_data`, raises `recv_req`, and the pop takes effect when `recv_ok` is also high. A request made while its ready signal is low does nothing. `fill_level` shows how many tokens are held.

The controller has two named states. SEED writes one reset token per host cycle and holds both ready signals low. RUN is the normal flow-controlled phase. The transition SEED→RUN (named SEED_DONE) happens on the clock edge that writes the last of the `LATENCY` reset tokens. There is no transition out of RUN except reset, which returns the controller to SEED.

Top module: `latency_token_channel`

## Requirements
- R1: While reset is active and in the SEED state afterwards, `send_ok` and `recv_ok` are 0. `fill_level` is 0 at reset release and rises by exactly 1 per clock until it reaches `LATENCY`, when the state becomes RUN.
- R2: The first `LATENCY` tokens popped after reset each equal the parameter `RESET_TOKEN`.
- R3: In RUN, `send_ok` is 1 exactly when `fill_level < DEPTH`. A `send_req` while `send_ok` is 0 changes neither `fill_level` nor the stored tokens.
- R4: In RUN, `recv_ok` is 1 exactly when `fill_level > 0`. A `recv_req` while `recv_ok` is 0 changes neither `fill_level` nor the stored tokens.
- R5: Tokens leave in the order they were accepted. Whenever `recv_ok` is 1, `recv_data` shows the oldest held token.
- R6: An accepted push and an accepted pop on the same clock leave `fill_level` unchanged.
- R7: In RUN, `fill_level` always equals `LATENCY` + accepted pushes − accepted pops since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| send_req | input | 1 | Producer finished a target cycle and offers a token |
| send_data | input | DATA_W | Token offered by the producer |
| send_ok | output | 1 | Channel can accept a token |
| recv_req | input | 1 | Consumer starts a target cycle and takes a token |
| recv_data | output | DATA_W | Oldest held token |
| recv_ok | output | 1 | A token is available |
| fill_level | output | $clog2(DEPTH+1) | Number of tokens held |

## Verification
The hardest situation to reach is a push and a pop offered together while the store is full, and again while it is empty. In those cases only one side is ready, so only that side may act. The stimulus gets there by first draining the seeded tokens with extra pop requests and no pushes. It then fills the store past capacity with pushes alone. Last, it offers both requests at full and at empty before a long mixed phase. A queue model in the bench follows every cycle and confirms the level, both ready signals and the head token.

// File: rtl/lat_chan_pkg.sv
package lat_chan_pkg;
    typedef enum logic [0:0] {
        ST_SEED = 1'b0,
        ST_RUN  = 1'b1
    } chan_state_e;
endpackage

// File: rtl/lat_chan_store.sv
module lat_chan_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] slots [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            slots[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_en) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (rd_en) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
        end
    end

    assign rd_data = slots[rd_ptr];

    // R5: the read pointer only moves when a pop is granted
    assert_rd_ptr_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_ptr));
endmodule

// File: rtl/lat_chan_ctrl.sv
module lat_chan_ctrl
    import lat_chan_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int LATENCY = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         send_req,
    input  logic                         recv_req,
    output logic                         send_ok,
    output logic                         recv_ok,
    output logic                         push,
    output logic                         pop,
    output logic                         seeding,
    output logic [$clog2(DEPTH+1)-1:0]   level
);
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int SEED_W = $clog2(LATENCY + 1);
    localparam logic [CNT_W-1:0]  FULL_LVL  = CNT_W'(DEPTH);
    localparam logic [SEED_W-1:0] SEED_LAST = SEED_W'(LATENCY - 1);

    chan_state_e       state, state_nx;
    logic [SEED_W-1:0] seed_cnt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_SEED;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_SEED: if (seed_cnt == SEED_LAST) state_nx = ST_RUN;
            ST_RUN:  state_nx = ST_RUN;
            default: state_nx = ST_SEED;
        endcase
    end

    // outputs
    always_comb begin
        send_ok = 1'b0;
        recv_ok = 1'b0;
        push    = 1'b0;
        pop     = 1'b0;
        seeding = 1'b0;
        unique case (state)
            ST_SEED: begin
                push    = 1'b1;
                seeding = 1'b1;
            end
            ST_RUN: begin
                send_ok = (level != FULL_LVL);
                recv_ok = (level != '0);
                push    = send_req && send_ok;
                pop     = recv_req && recv_ok;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seed_cnt <= '0;
            level    <= '0;
        end else begin
            if (state == ST_SEED) begin
                seed_cnt <= seed_cnt + 1'b1;
            end
            unique case ({push, pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        level <= FULL_LVL);
    assert_seed_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        seeding |-> (!send_ok && !recv_ok));
    assert_full_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (level == FULL_LVL) && !pop |=> level == FULL_LVL);
    assert_empty_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) && (level == '0) && !push |=> level == '0);
    assert_both_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        push && pop |=> $stable(level));
    assert_push_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push && !pop |=> level == $past(level) + 1'b1);
endmodule

// File: rtl/latency_token_channel.sv
module latency_token_channel #(
    parameter int                DATA_W      = 16,
    parameter int                DEPTH       = 8,
    parameter int                LATENCY     = 3,
    parameter logic [DATA_W-1:0] RESET_TOKEN = '0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         send_req,
    input  logic [DATA_W-1:0]            send_data,
    output logic                         send_ok,
    input  logic                         recv_req,
    output logic [DATA_W-1:0]            recv_data,
    output logic                         recv_ok,
    output logic [$clog2(DEPTH+1)-1:0]   fill_level
);
    logic push, pop, seeding;
    logic [DATA_W-1:0] wr_word;

    initial begin
        if (LATENCY < 1 || DEPTH < LATENCY) begin
            $error("latency_token_channel: need 1 <= LATENCY <= DEPTH");
        end
    end

    lat_chan_ctrl #(.DEPTH(DEPTH), .LATENCY(LATENCY)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .send_req(send_req), .recv_req(recv_req),
        .send_ok(send_ok), .recv_ok(recv_ok), .push(push), .pop(pop),
        .seeding(seeding), .level(fill_level)
    );

    assign wr_word = seeding ? RESET_TOKEN : send_data;

    lat_chan_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(push), .wr_data(wr_word),
        .rd_en(pop), .rd_data(recv_data)
    );

    assert_head_known_R5: assert property (@(posedge clk) disable iff (!rst_n)
        recv_ok |-> !$isunknown(recv_data));
endmodule

// File: tb/latency_token_channel_bench.sv
module latency_token_channel_bench;
    localparam int DATA_W = 16;
    localparam int DEPTH  = 8;
    localparam int LAT    = 3;
    localparam logic [DATA_W-1:0] RTOK = 16'h5A3C;
    localparam int LW = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic send_req = 1'b0, recv_req = 1'b0;
    logic [DATA_W-1:0] send_data = '0;
    logic send_ok, recv_ok;
    logic [DATA_W-1:0] recv_data;
    logic [LW-1:0] fill_level;

    int errors = 0, checks = 0;
    int model_q[$];
    int n_push = 0, n_pop = 0;
    int next_val = 1;
    bit done = 0;

    always #4 clk = ~clk;

    latency_token_channel #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LATENCY(LAT),
        .RESET_TOKEN(RTOK)) u_latency_token_channel (
        .clk(clk), .rst_n(rst_n), .send_req(send_req), .send_data(send_data),
        .send_ok(send_ok), .recv_req(recv_req), .recv_data(recv_data),
        .recv_ok(recv_ok), .fill_level(fill_level)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // entered and left at a negedge
    task automatic step(input bit s, input bit r);
        int lvl = model_q.size();
        bit fs, fr;
        chk(int'(fill_level) == lvl, "R7 level", int'(fill_level), lvl);
        chk(int'(fill_level) == LAT + n_push - n_pop, "R7 balance", int'(fill_level), LAT + n_push - n_pop);
        chk(send_ok == (lvl < DEPTH), "R3 send_ok", send_ok, lvl < DEPTH);
        chk(recv_ok == (lvl > 0), "R4 recv_ok", recv_ok, lvl > 0);
        if (lvl > 0) begin
            if (n_pop < LAT) chk(recv_data == RTOK, "R2 seed token", recv_data, RTOK);
            chk(int'(recv_data) == model_q[0], "R5 head", recv_data, model_q[0]);
        end
        fs = s && (lvl < DEPTH);
        fr = r && (lvl > 0);
        send_req = s; recv_req = r;
        send_data = DATA_W'(next_val);
        @(posedge clk);
        if (fr) begin void'(model_q.pop_front()); n_pop++; end
        if (fs) begin model_q.push_back(next_val); n_push++; next_val++; end
        @(negedge clk);
        send_req = 0; recv_req = 0;
        if (fs && fr) chk(int'(fill_level) == lvl, "R6 both", int'(fill_level), lvl);
        if (s && !fs) chk(int'(fill_level) == lvl - (fr ? 1 : 0), "R3 ignored push", int'(fill_level), lvl);
        if (r && !fr) chk(int'(fill_level) == lvl + (fs ? 1 : 0), "R4 ignored pop", int'(fill_level), lvl);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        chk(send_ok == 0 && recv_ok == 0, "R1 reset ready", {send_ok, recv_ok}, 0);
        rst_n = 1'b1;
        for (int k = 0; k < LAT; k++) begin
            chk(int'(fill_level) == k, "R1 seed level", int'(fill_level), k);
            chk(send_ok == 0 && recv_ok == 0, "R1 seed ready", {send_ok, recv_ok}, 0);
            @(negedge clk);
        end
        for (int k = 0; k < LAT; k++) model_q.push_back(int'(RTOK));
        // drain seeds and poke an empty store
        for (int k = 0; k < LAT + 2; k++) step(0, 1);
        step(1, 1);              // both at empty: only push
        // fill past capacity
        for (int k = 0; k < DEPTH + 3; k++) step(1, 0);
        step(1, 1);              // both at full: only pop
        step(1, 1);              // both mid-level: R6
        for (int k = 0; k < 600; k++) step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        for (int k = 0; k < DEPTH + 2; k++) step(0, 1);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule